// File: doc/BRIEF.md
# Opcode-Driven Control Register and Table Port

This block turns short command frames, received one byte at a time, into updates of a 19-entry 8-bit control register file and a 256-byte lookup table. Each frame starts with an opcode byte, carries up to 16 argument bytes, and ends on a separate frame-end strobe. Opcodes set the PWM settings, start and stop a note, change the hold delay, steer and load read and write pointers, stream data into registers, the table or an external nonvolatile store, and ask for the table to be saved. Single-cycle strobes tell the neighbouring timer and PWM blocks when their settings have changed.

Reads are served one byte per request. A selector register chooses one of three read pointers (registers, table, nonvolatile store), and that pointer post-increments after each byte. Writes use the same scheme with a second set of pointers and a write selector. All pointers live inside the register file, so a host can inspect or reload them with ordinary commands. The serial bus PHY and the storage device sit outside the block.

Top module: `cmd_regport`

## Requirements
- R1: After reset, register 7 holds 4, register 8 holds 5, register 10 holds 4, register 11 holds 127, register 12 holds 255, register 13 holds 5, register 16 holds 14, register 18 holds 6, and all other registers hold 0. Register 14 always reads the `phase_in` input, and writes to it have no effect.
- R2: A frame runs when `in_end` is strobed. A frame of only an opcode still runs. A frame-end with no bytes, or after more than 17 bytes, changes nothing. `in_valid` is ignored in a cycle where `in_end` is high.
- R3: Opcode 0 copies up to three arguments into registers 11, 12 and 13 in that order. Extra arguments are ignored and missing ones leave their registers unchanged. The opcode pulses `pwm_upd`.
- R4: Opcode 2 copies up to three arguments into registers 8, 9 and 10 and pulses `note_on`. If register 8 then exceeds register 16, register 8 is set to register 16 and error bit 0x04 of register 15 is set. `presc_reload` pulses with `note_on` only when all three arguments are present.
- R5: Opcode 3 pulses `note_off`. Opcode 6 pulses `save_req`. Opcode 7 copies up to two arguments into registers 17 and 18. Other opcodes do nothing.
- R6: Opcode 4 puts its first argument into register 3. If a second argument is present and the first is 0, 1 or 2, the second argument is loaded into that read pointer (register 0, 1 or 2).
- R7: A `rd_req` pulse returns, one cycle later with `rd_valid`, the byte at the pointer chosen by register 3, then increments that pointer modulo 256. Source 0 reads register[reg0] (0 above 18, `phase_in` at 14). Source 1 reads table[reg1]. Source 2 reads `nv_rdata` with `nv_raddr` = reg2.
- R8: A read with register 3 above 2 sets error bit 0x01 and gives no `rd_valid`. Error bits only clear through a write to register 15.
- R9: For opcode 5 with at least one argument, bits [2:0] of the first argument select the destination. If they are not 4, 5 or 6, error bit 0x02 is set and nothing else changes. Otherwise register 7 takes the selection, and if bit 3 is set and a second argument exists, that argument loads the selected pointer register.
- R10: Each remaining opcode-5 argument is handled in its own cycle while `busy` is high, and is written at the pointer named by register 7, after which that pointer increments. Destination 4 writes register[ptr] (ignored above 18 or at 14; the data wins over the increment when ptr is 4). Destination 5 writes table[ptr]. Destination 6 pulses `nv_we` with `nv_waddr` = ptr and `nv_wdata`.
- R11: While `busy` is high, `in_valid`, `in_end` and `rd_req` are ignored.
- R12: Each strobe output is high for exactly one cycle, the cycle after the frame end, and at most one of `pwm_upd`, `note_on`, `note_off` and `save_req` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte present |
| in_byte | input | 8 | Command byte |
| in_end | input | 1 | Frame-end strobe |
| rd_req | input | 1 | Read one byte |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data |
| phase_in | input | 8 | Live value shown as register 14 |
| nv_raddr | output | 8 | Nonvolatile read address |
| nv_rdata | input | 8 | Nonvolatile read data |
| nv_we | output | 1 | Nonvolatile write pulse |
| nv_waddr | output | 8 | Nonvolatile write address |
| nv_wdata | output | 8 | Nonvolatile write data |
| busy | output | 1 | Streaming write in progress |
| pwm_upd | output | 1 | PWM settings changed |
| note_on | output | 1 | Start note sequence |
| presc_reload | output | 1 | Reload tick prescaler |
| note_off | output | 1 | Stop note |
| save_req | output | 1 | Save table request |
| regs_flat | output | 152 | Register k at bits [8k+7:8k] |

## Verification
On every cycle, the assertions check that read data only follows an accepted request, that nonvolatile writes only come from the streaming phase, that the event strobes are exclusive and caused by a frame end, that a note start never leaves the coarse count above its limit, and that error bits are never cleared outside a streaming write. Argument-count handling, pointer post-increment, write-destination steering, table read-back, overflow discard and the ignoring of inputs during `busy` depend on whole frames. Only the bench's scenarios, compared against its reference model on every cycle, can show these.

// File: rtl/cmd_regport_pkg.sv
package cmd_regport_pkg;
  localparam int BW        = 8;
  localparam int NREG      = 19;
  localparam int FRAME_MAX = 17;

  localparam int IX_RD_REG  = 0;
  localparam int IX_RD_TBL  = 1;
  localparam int IX_RD_NV   = 2;
  localparam int IX_RD_SEL  = 3;
  localparam int IX_WR_REG  = 4;
  localparam int IX_WR_TBL  = 5;
  localparam int IX_WR_NV   = 6;
  localparam int IX_WR_SEL  = 7;
  localparam int IX_COARSE  = 8;
  localparam int IX_FINE    = 9;
  localparam int IX_PRESC   = 10;
  localparam int IX_DUTY    = 11;
  localparam int IX_PHASE   = 14;
  localparam int IX_ERR     = 15;
  localparam int IX_CMAX    = 16;
  localparam int IX_HCOARSE = 17;

  localparam logic [BW-1:0] OP_PWM    = 8'd0;
  localparam logic [BW-1:0] OP_NOTEON = 8'd2;
  localparam logic [BW-1:0] OP_NOTEOFF= 8'd3;
  localparam logic [BW-1:0] OP_RDSET  = 8'd4;
  localparam logic [BW-1:0] OP_WRITE  = 8'd5;
  localparam logic [BW-1:0] OP_SAVE   = 8'd6;
  localparam logic [BW-1:0] OP_HOLD   = 8'd7;

  localparam logic [BW-1:0] ERR_RDSRC = 8'h01;
  localparam logic [BW-1:0] ERR_WRDST = 8'h02;
  localparam logic [BW-1:0] ERR_CLAMP = 8'h04;

  function automatic logic [BW-1:0] reg_reset(input int idx);
    case (idx)
      7:       return 8'd4;
      8:       return 8'd5;
      10:      return 8'd4;
      11:      return 8'd127;
      12:      return 8'd255;
      13:      return 8'd5;
      16:      return 8'd14;
      18:      return 8'd6;
      default: return 8'd0;
    endcase
  endfunction
endpackage

// File: rtl/cmd_frame_buf.sv
module cmd_frame_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 17,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      in_valid,
  input  logic                      in_end,
  input  logic [W-1:0]              in_byte,
  output logic [DEPTH-1:0][W-1:0]   bytes,
  output logic [CW-1:0]             cnt,
  output logic                      ovf
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          wr_en;
  logic [W-1:0]  slot_q [DEPTH];

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    wr_en = 1'b0;
    if (en) begin
      if (in_end) begin
        cnt_d = '0;
        ovf_d = 1'b0;
      end else if (in_valid) begin
        if (cnt_q == CW'(DEPTH)) begin
          ovf_d = 1'b1;
        end else begin
          wr_en = 1'b1;
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && cnt_q == CW'(g)) slot_q[g] <= in_byte;
    end
    assign bytes[g] = slot_q[g];
  end

  assign cnt = cnt_q;
  assign ovf = ovf_q;
endmodule

// File: rtl/cmd_table.sv
module cmd_table #(
  parameter int W      = 8,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/cmd_exec.sv
module cmd_exec
  import cmd_regport_pkg::*;
#(
  parameter int DEPTH = FRAME_MAX,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_end,
  input  logic                     rd_req,
  input  logic [DEPTH-1:0][BW-1:0] fb_bytes,
  input  logic [CW-1:0]            fb_cnt,
  input  logic                     fb_ovf,
  input  logic [BW-1:0]            phase_in,
  input  logic [BW-1:0]            tbl_rdata,
  output logic [BW-1:0]            tbl_raddr,
  output logic                     tbl_we,
  output logic [BW-1:0]            tbl_waddr,
  output logic [BW-1:0]            tbl_wdata,
  input  logic [BW-1:0]            nv_rdata,
  output logic [BW-1:0]            nv_raddr,
  output logic                     nv_we,
  output logic [BW-1:0]            nv_waddr,
  output logic [BW-1:0]            nv_wdata,
  output logic                     busy,
  output logic                     rd_valid,
  output logic [BW-1:0]            rd_data,
  output logic                     pwm_upd,
  output logic                     note_on,
  output logic                     presc_reload,
  output logic                     note_off,
  output logic                     save_req,
  output logic [NREG*BW-1:0]       regs_flat
);
  logic [BW-1:0] regs_q [NREG];
  logic [BW-1:0] regs_d [NREG];
  logic          busy_q, busy_d;
  logic [CW-1:0] widx_q, widx_d, wlast_q, wlast_d;
  logic          rv_q, rv_d;
  logic [BW-1:0] rd_q, rd_d;
  logic          pwm_q, pwm_d, non_q, non_d, pre_q, pre_d, noff_q, noff_d, sav_q, sav_d;
  logic          nvwe_q, nvwe_d;
  logic [BW-1:0] nva_q, nva_d, nvd_q, nvd_d;

  logic [BW-1:0] reg_rd_val, wr_sel, wr_ptr, wval, op, b1, b2, err_set;
  logic [CW-1:0] nargs, start;

  assign op    = fb_bytes[0];
  assign b1    = fb_bytes[1];
  assign b2    = fb_bytes[2];
  assign nargs = fb_cnt - 1'b1;
  assign wval  = fb_bytes[widx_q];
  assign wr_sel = regs_q[IX_WR_SEL];

  // register-source read mux
  always_comb begin
    reg_rd_val = '0;
    for (int k = 0; k < NREG; k++) begin
      if (regs_q[IX_RD_REG] == BW'(k))
        reg_rd_val = (k == IX_PHASE) ? phase_in : regs_q[k];
    end
  end

  // pointer selected by the write selector
  always_comb begin
    wr_ptr = '0;
    for (int k = IX_WR_REG; k <= IX_WR_NV; k++) begin
      if (wr_sel == BW'(k)) wr_ptr = regs_q[k];
    end
  end

  always_comb begin
    for (int k = 0; k < NREG; k++) regs_d[k] = regs_q[k];
    busy_d  = busy_q;
    widx_d  = widx_q;
    wlast_d = wlast_q;
    rv_d    = 1'b0;
    rd_d    = rd_q;
    pwm_d   = 1'b0;
    non_d   = 1'b0;
    pre_d   = 1'b0;
    noff_d  = 1'b0;
    sav_d   = 1'b0;
    nvwe_d  = 1'b0;
    nva_d   = nva_q;
    nvd_d   = nvd_q;
    tbl_we    = 1'b0;
    tbl_waddr = wr_ptr;
    tbl_wdata = wval;
    err_set = '0;
    start   = '0;

    if (busy_q) begin
      // streaming write: one argument per cycle
      widx_d = widx_q + 1'b1;
      if (widx_q + 1'b1 == wlast_q) busy_d = 1'b0;
      if (wr_sel == BW'(IX_WR_REG)) begin
        regs_d[IX_WR_REG] = wr_ptr + 1'b1;
        for (int k = 0; k < NREG; k++) begin
          if (wr_ptr == BW'(k) && k != IX_PHASE) regs_d[k] = wval;
        end
      end else if (wr_sel == BW'(IX_WR_TBL)) begin
        regs_d[IX_WR_TBL] = wr_ptr + 1'b1;
        tbl_we = 1'b1;
      end else if (wr_sel == BW'(IX_WR_NV)) begin
        regs_d[IX_WR_NV] = wr_ptr + 1'b1;
        nvwe_d = 1'b1;
        nva_d  = wr_ptr;
        nvd_d  = wval;
      end else begin
        err_set = ERR_WRDST;
        busy_d  = 1'b0;
      end
    end else if (in_end) begin
      if (fb_cnt != '0 && !fb_ovf) begin
        case (op)
          OP_PWM: begin
            for (int i = 0; i < 3; i++)
              if (CW'(i) < nargs) regs_d[IX_DUTY + i] = fb_bytes[i + 1];
            pwm_d = 1'b1;
          end
          OP_NOTEON: begin
            for (int i = 0; i < 3; i++)
              if (CW'(i) < nargs) regs_d[IX_COARSE + i] = fb_bytes[i + 1];
            if (regs_d[IX_COARSE] > regs_q[IX_CMAX]) begin
              regs_d[IX_COARSE] = regs_q[IX_CMAX];
              err_set = ERR_CLAMP;
            end
            non_d = 1'b1;
            pre_d = (nargs >= CW'(3));
          end
          OP_NOTEOFF: noff_d = 1'b1;
          OP_SAVE:    sav_d  = 1'b1;
          OP_HOLD: begin
            for (int i = 0; i < 2; i++)
              if (CW'(i) < nargs) regs_d[IX_HCOARSE + i] = fb_bytes[i + 1];
          end
          OP_RDSET: begin
            if (nargs >= CW'(1)) regs_d[IX_RD_SEL] = b1;
            if (nargs >= CW'(2)) begin
              for (int k = IX_RD_REG; k <= IX_RD_NV; k++)
                if (b1 == BW'(k)) regs_d[k] = b2;
            end
          end
          OP_WRITE: begin
            if (nargs != '0) begin
              if (b1[2:0] < 3'd4 || b1[2:0] == 3'd7) begin
                err_set = ERR_WRDST;
              end else begin
                regs_d[IX_WR_SEL] = {5'd0, b1[2:0]};
                start = CW'(2);
                if (b1[3] && nargs > CW'(1)) begin
                  regs_d[b1[2:0]] = b2;
                  start = CW'(3);
                end
                if (start < fb_cnt) begin
                  busy_d  = 1'b1;
                  widx_d  = start;
                  wlast_d = fb_cnt;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end else if (rd_req) begin
      if (regs_q[IX_RD_SEL] == BW'(IX_RD_REG)) begin
        rv_d = 1'b1;
        rd_d = reg_rd_val;
        regs_d[IX_RD_REG] = regs_q[IX_RD_REG] + 1'b1;
      end else if (regs_q[IX_RD_SEL] == BW'(IX_RD_TBL)) begin
        rv_d = 1'b1;
        rd_d = tbl_rdata;
        regs_d[IX_RD_TBL] = regs_q[IX_RD_TBL] + 1'b1;
      end else if (regs_q[IX_RD_SEL] == BW'(IX_RD_NV)) begin
        rv_d = 1'b1;
        rd_d = nv_rdata;
        regs_d[IX_RD_NV] = regs_q[IX_RD_NV] + 1'b1;
      end else begin
        err_set = ERR_RDSRC;
      end
    end

    regs_d[IX_ERR]   = regs_d[IX_ERR] | err_set;
    regs_d[IX_PHASE] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) regs_q[k] <= reg_reset(k);
      busy_q  <= 1'b0;
      widx_q  <= '0;
      wlast_q <= '0;
      rv_q    <= 1'b0;
      rd_q    <= '0;
      pwm_q   <= 1'b0;
      non_q   <= 1'b0;
      pre_q   <= 1'b0;
      noff_q  <= 1'b0;
      sav_q   <= 1'b0;
      nvwe_q  <= 1'b0;
      nva_q   <= '0;
      nvd_q   <= '0;
    end else begin
      for (int k = 0; k < NREG; k++) regs_q[k] <= regs_d[k];
      busy_q  <= busy_d;
      widx_q  <= widx_d;
      wlast_q <= wlast_d;
      rv_q    <= rv_d;
      rd_q    <= rd_d;
      pwm_q   <= pwm_d;
      non_q   <= non_d;
      pre_q   <= pre_d;
      noff_q  <= noff_d;
      sav_q   <= sav_d;
      nvwe_q  <= nvwe_d;
      nva_q   <= nva_d;
      nvd_q   <= nvd_d;
    end
  end

  always_comb begin
    for (int k = 0; k < NREG; k++)
      regs_flat[k*BW +: BW] = (k == IX_PHASE) ? phase_in : regs_q[k];
  end

  assign tbl_raddr    = regs_q[IX_RD_TBL];
  assign nv_raddr     = regs_q[IX_RD_NV];
  assign nv_we        = nvwe_q;
  assign nv_waddr     = nva_q;
  assign nv_wdata     = nvd_q;
  assign busy         = busy_q;
  assign rd_valid     = rv_q;
  assign rd_data      = rd_q;
  assign pwm_upd      = pwm_q;
  assign note_on      = non_q;
  assign presc_reload = pre_q;
  assign note_off     = noff_q;
  assign save_req     = sav_q;
endmodule

// File: rtl/cmd_regport.sv
module cmd_regport
  import cmd_regport_pkg::*;
#(
  parameter int FRAME_LEN = FRAME_MAX,
  localparam int CW       = $clog2(FRAME_LEN + 1),
  localparam int TBL_N    = 1 << BW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [BW-1:0]      in_byte,
  input  logic               in_end,
  input  logic               rd_req,
  output logic               rd_valid,
  output logic [BW-1:0]      rd_data,
  input  logic [BW-1:0]      phase_in,
  output logic [BW-1:0]      nv_raddr,
  input  logic [BW-1:0]      nv_rdata,
  output logic               nv_we,
  output logic [BW-1:0]      nv_waddr,
  output logic [BW-1:0]      nv_wdata,
  output logic               busy,
  output logic               pwm_upd,
  output logic               note_on,
  output logic               presc_reload,
  output logic               note_off,
  output logic               save_req,
  output logic [NREG*BW-1:0] regs_flat
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  logic [FRAME_LEN-1:0][BW-1:0] fb_bytes;
  logic [CW-1:0]                fb_cnt;
  logic                         fb_ovf;
  logic                         tbl_we;
  logic [BW-1:0]                tbl_waddr, tbl_wdata, tbl_raddr, tbl_rdata;

  cmd_frame_buf #(.W(BW), .DEPTH(FRAME_LEN)) u_fbuf (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .en       (!busy),
    .in_valid (in_valid),
    .in_end   (in_end),
    .in_byte  (in_byte),
    .bytes    (fb_bytes),
    .cnt      (fb_cnt),
    .ovf      (fb_ovf)
  );

  cmd_table #(.W(BW), .DEPTH(TBL_N)) u_tbl (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (tbl_raddr),
    .rdata (tbl_rdata)
  );

  cmd_exec #(.DEPTH(FRAME_LEN)) u_exec (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .in_end       (in_end),
    .rd_req       (rd_req),
    .fb_bytes     (fb_bytes),
    .fb_cnt       (fb_cnt),
    .fb_ovf       (fb_ovf),
    .phase_in     (phase_in),
    .tbl_rdata    (tbl_rdata),
    .tbl_raddr    (tbl_raddr),
    .tbl_we       (tbl_we),
    .tbl_waddr    (tbl_waddr),
    .tbl_wdata    (tbl_wdata),
    .nv_rdata     (nv_rdata),
    .nv_raddr     (nv_raddr),
    .nv_we        (nv_we),
    .nv_waddr     (nv_waddr),
    .nv_wdata     (nv_wdata),
    .busy         (busy),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .pwm_upd      (pwm_upd),
    .note_on      (note_on),
    .presc_reload (presc_reload),
    .note_off     (note_off),
    .save_req     (save_req),
    .regs_flat    (regs_flat)
  );
endmodule

// File: rtl/cmd_regport_chk.sv
module cmd_regport_chk
  import cmd_regport_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_end,
  input logic               rd_req,
  input logic               rd_valid,
  input logic               busy,
  input logic               nv_we,
  input logic               pwm_upd,
  input logic               note_on,
  input logic               presc_reload,
  input logic               note_off,
  input logic               save_req,
  input logic [NREG*BW-1:0] regs_flat
);
  logic [BW-1:0] err_v, coarse_v, cmax_v;
  logic          any_evt;
  assign err_v    = regs_flat[IX_ERR*BW +: BW];
  assign coarse_v = regs_flat[IX_COARSE*BW +: BW];
  assign cmax_v   = regs_flat[IX_CMAX*BW +: BW];
  assign any_evt  = pwm_upd | note_on | note_off | save_req;

  // R7
  rd_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rd_req) && !$past(busy) && !$past(in_end)));

  // R10
  nv_we_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |-> $past(busy));

  // R12
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pwm_upd, note_on, note_off, save_req}));

  // R12
  evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |-> ($past(in_end) && !$past(busy)));

  // R4
  coarse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    note_on |-> (coarse_v <= cmax_v));

  // R4
  presc_with_note_chk: assert property (@(posedge clk) disable iff (!rst_n)
    presc_reload |-> note_on);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> ((err_v & $past(err_v)) == $past(err_v)));
endmodule

bind cmd_regport cmd_regport_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_end       (in_end),
  .rd_req       (rd_req),
  .rd_valid     (rd_valid),
  .busy         (busy),
  .nv_we        (nv_we),
  .pwm_upd      (pwm_upd),
  .note_on      (note_on),
  .presc_reload (presc_reload),
  .note_off     (note_off),
  .save_req     (save_req),
  .regs_flat    (regs_flat)
);

// File: tb/tb_cmd_regport.sv
module tb_cmd_regport;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [7:0]   in_byte = '0;
  logic         in_end = 1'b0;
  logic         rd_req = 1'b0;
  logic         rd_valid;
  logic [7:0]   rd_data;
  logic [7:0]   phase_in = 8'h02;
  logic [7:0]   nv_raddr, nv_rdata, nv_waddr, nv_wdata;
  logic         nv_we, busy, pwm_upd, note_on, presc_reload, note_off, save_req;
  logic [151:0] regs_flat;

  assign nv_rdata = nv_raddr ^ 8'hA5;

  cmd_regport dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_end(in_end), .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .phase_in(phase_in), .nv_raddr(nv_raddr), .nv_rdata(nv_rdata),
    .nv_we(nv_we), .nv_waddr(nv_waddr), .nv_wdata(nv_wdata), .busy(busy),
    .pwm_upd(pwm_upd), .note_on(note_on), .presc_reload(presc_reload),
    .note_off(note_off), .save_req(save_req), .regs_flat(regs_flat)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  // reference model state
  int m_reg[19];
  int m_tbl[256];
  int m_q[$];
  int m_fr[$];
  int m_ovf, m_busy, m_widx, m_wlast, m_err;
  bit m_rv, m_pwm, m_non, m_pre, m_noff, m_save, m_nvwe;
  int m_rd, m_nva, m_nvd;

  function automatic int rst_val(int k);
    case (k)
      7: return 4;  8: return 5;  10: return 4; 11: return 127;
      12: return 255; 13: return 5; 16: return 14; 18: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic m_reset();
    for (int k = 0; k < 19; k++) m_reg[k] = rst_val(k);
    m_q.delete(); m_fr.delete();
    m_ovf = 0; m_busy = 0; m_widx = 0; m_wlast = 0;
    m_rv = 0; m_rd = 0; m_pwm = 0; m_non = 0; m_pre = 0; m_noff = 0; m_save = 0;
    m_nvwe = 0; m_nva = 0; m_nvd = 0;
  endtask

  task automatic m_frame();
    int n, op, s, st;
    n = m_fr.size() - 1;
    op = m_fr[0];
    case (op)
      0: begin
        for (int i = 0; i < 3 && i < n; i++) m_reg[11+i] = m_fr[i+1];
        m_pwm = 1;
      end
      2: begin
        for (int i = 0; i < 3 && i < n; i++) m_reg[8+i] = m_fr[i+1];
        if (m_reg[8] > m_reg[16]) begin m_reg[8] = m_reg[16]; m_err |= 4; end
        m_non = 1;
        m_pre = (n >= 3);
      end
      3: m_noff = 1;
      6: m_save = 1;
      7: for (int i = 0; i < 2 && i < n; i++) m_reg[17+i] = m_fr[i+1];
      4: begin
        if (n >= 1) m_reg[3] = m_fr[1];
        if (n >= 2 && m_fr[1] <= 2) m_reg[m_fr[1]] = m_fr[2];
      end
      5: if (n >= 1) begin
        s = m_fr[1] & 7;
        if (s < 4 || s > 6) m_err |= 2;
        else begin
          m_reg[7] = s;
          st = 2;
          if ((m_fr[1] & 8) != 0 && n > 1) begin m_reg[s] = m_fr[2]; st = 3; end
          if (st < m_fr.size()) begin m_busy = 1; m_widx = st; m_wlast = m_fr.size(); end
        end
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_reset();
    end else begin
      m_err = 0;
      m_rv = 0; m_pwm = 0; m_non = 0; m_pre = 0; m_noff = 0; m_save = 0; m_nvwe = 0;
      if (m_busy != 0) begin
        int sel, p, v;
        sel = m_reg[7];
        if (sel >= 4 && sel <= 6) begin
          p = m_reg[sel];
          v = m_fr[m_widx];
          m_reg[sel] = (p + 1) & 255;
          if (sel == 4) begin
            if (p < 19 && p != 14) m_reg[p] = v;
          end else if (sel == 5) begin
            m_tbl[p] = v;
          end else begin
            m_nvwe = 1; m_nva = p; m_nvd = v;
          end
          m_widx++;
          if (m_widx == m_wlast) m_busy = 0;
        end else begin
          m_err |= 2; m_busy = 0;
        end
      end else if (in_end) begin
        if (m_q.size() > 0 && m_ovf == 0) begin
          m_fr = m_q;
          m_frame();
        end
        m_q.delete();
        m_ovf = 0;
      end else begin
        if (in_valid) begin
          if (m_q.size() == 17) m_ovf = 1;
          else m_q.push_back(int'(in_byte));
        end
        if (rd_req) begin
          int p;
          case (m_reg[3])
            0: begin
              p = m_reg[0];
              m_rd = (p == 14) ? int'(phase_in) : (p < 19 ? m_reg[p] : 0);
              m_reg[0] = (p + 1) & 255; m_rv = 1;
            end
            1: begin m_rd = m_tbl[m_reg[1]]; m_reg[1] = (m_reg[1] + 1) & 255; m_rv = 1; end
            2: begin m_rd = m_reg[2] ^ 8'hA5; m_reg[2] = (m_reg[2] + 1) & 255; m_rv = 1; end
            default: m_err |= 1;
          endcase
        end
      end
      m_reg[15] |= m_err;
      m_reg[14] = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      for (int k = 0; k < 19; k++)
        chk(cur_req, $sformatf("reg%0d", k), int'(regs_flat[k*8 +: 8]),
            (k == 14) ? int'(phase_in) : m_reg[k]);
      chk(cur_req, "busy", int'(busy), m_busy);
      chk(cur_req, "rd_valid", int'(rd_valid), int'(m_rv));
      if (m_rv) chk(cur_req, "rd_data", int'(rd_data), m_rd);
      chk(cur_req, "R12 strobes",
          int'({pwm_upd, note_on, presc_reload, note_off, save_req}),
          int'({m_pwm, m_non, m_pre, m_noff, m_save}));
      chk(cur_req, "nv_we", int'(nv_we), int'(m_nvwe));
      if (m_nvwe) begin
        chk(cur_req, "nv_waddr", int'(nv_waddr), m_nva);
        chk(cur_req, "nv_wdata", int'(nv_wdata), m_nvd);
      end
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic send(input int fr[$], input bit wait_done = 1'b1);
    foreach (fr[i]) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = 8'(fr[i]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_end   = 1'b1;
    @(negedge clk);
    in_end = 1'b0;
    if (wait_done) wait_idle();
  endtask

  task automatic rd(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ovf_fr[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset values against literal expectations
    cur_req = "R1";
    for (int k = 0; k < 19; k++)
      chk("R1", $sformatf("reset reg%0d", k), int'(regs_flat[k*8 +: 8]),
          (k == 14) ? 2 : rst_val(k));
    cmp_on = 1'b1;
    @(negedge clk);

    cur_req = "R3";
    send('{0, 10, 20, 30});
    send('{0, 1, 2, 3, 99, 98});
    send('{0, 50});

    cur_req = "R2";
    send('{0});
    ovf_fr.delete();
    for (int i = 0; i < 18; i++) ovf_fr.push_back(i == 0 ? 7 : 200 + i);
    send(ovf_fr);
    send('{});
    chk("R2", "hold coarse after overflow frame", int'(regs_flat[17*8 +: 8]), 0);

    cur_req = "R4";
    send('{2, 3, 7});
    send('{2, 40, 1, 5});
    chk("R4", "clamped coarse", int'(regs_flat[8*8 +: 8]), 14);

    cur_req = "R5";
    send('{3});
    send('{6});
    send('{7, 9, 8});
    send('{1, 4});

    cur_req = "R9";
    send('{5, 8'h0C, 11, 77, 88});
    chk("R9", "written duty", int'(regs_flat[11*8 +: 8]), 77);
    send('{5, 8'h03, 1});
    send('{5, 8'h05});

    cur_req = "R10";
    send('{5, 8'h0D, 8'h20, 1, 2, 3});
    send('{5, 8'h0E, 8'h40, 9, 8});
    send('{5, 8'h0C, 14, 55});
    send('{5, 8'h0C, 30, 1});
    send('{5, 8'h0C, 4, 16});

    cur_req = "R6";
    send('{4, 0, 11});
    send('{4, 9, 3});
    send('{4, 0});

    cur_req = "R7";
    rd(3);
    send('{4, 0, 13});
    rd(3);
    send('{4, 1, 8'h20});
    rd(3);
    send('{4, 2, 8'h40});
    rd(2);

    cur_req = "R8";
    send('{4, 3});
    rd(1);
    chk("R8", "error bits", int'(regs_flat[15*8 +: 8]) & 1, 1);
    send('{5, 8'h0C, 15, 0});

    cur_req = "R11";
    send('{5, 8'h0D, 8'h50, 11, 12, 13, 14, 15, 16}, 1'b0);
    for (int i = 0; i < 4; i++) begin
      rd_req = 1'b1; in_valid = 1'b1; in_byte = 8'h99; in_end = (i == 3);
      @(negedge clk);
    end
    rd_req = 1'b0; in_valid = 1'b0; in_end = 1'b0;
    wait_idle();
    send('{3});
    send('{4, 1, 8'h50});
    rd(6);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule